// File: doc/BRIEF.md
# Weighted Single-Change Stimulus Generator

This block produces a stream of test vectors for a circuit with several primary inputs. From one vector to the next, at most one input bit flips, and inputs with a larger weight flip more often. Each clock, a maximal-length shift register picks one slot out of 2^n. A one-hot decoder then hands that slot to the toggle element of whichever input owns it. Each input owns a contiguous run of slots, and the length of the run is that input's weight.

Software loads a configuration in one strobe. The configuration holds a slot count per input, a hold mask and a starting vector. The block derives each input's slot range from running sums of the counts. It refuses a configuration whose counts add up to more than the slot space. An input marked as held keeps its starting value for the whole run, which suits the reset and clock pins of the circuit under test. A slot that no input owns, or that a held input owns, produces a vector with no change, and the report output then shows no index.

Top module: `wsic_pattern_gen`

## Requirements
- R1: After reset, `stimOut` is all zeros, `changedValid` is 0 and `cfgError` is 0. Every slot count is zero, so enabled cycles produce no change.
- R2: The slot register resets to `SEED` (default 1), and an accepted load returns it to `SEED`. Each stepping cycle it becomes `{s[n-2:0], ^(s & TAPS)}`, with default `TAPS` = 6'b110000. This gives a period of 63 that never contains zero.
- R3: Slot counts are packed in `cfgSlots`: input k uses bits [k*(n+1) +: n+1]. Input k owns the slot values from P_k up to P_k + j_k - 1, where P_k is the sum of j_i over all i < k. The slot used on a step is the register value before it advances.
- R4: On a stepping cycle whose slot belongs to a non-held input k, bit k of `stimOut` flips at that clock edge. On the same edge `changedValid` becomes 1 and `changedIdx` becomes k.
- R5: On a stepping cycle whose slot is owned by no input, `stimOut` is unchanged and `changedValid` is 0.
- R6: Apart from the edge that applies an accepted load, no edge changes more than one bit of `stimOut`.
- R7: A held input (`cfgHold[k]` = 1 at load) keeps its starting value. Its slots give vectors with no change and `changedValid` = 0.
- R8: A load whose counts sum to at most 2^n is accepted. At that edge `stimOut` takes `cfgInit`, the slot register reseeds, `cfgError` clears and `changedValid` is 0.
- R9: A load whose counts sum to more than 2^n is rejected. `cfgError` becomes 1 and stays set until the next accepted load. The previous configuration, `stimOut` and the slot register are kept, and `changedValid` is 0.
- R10: With `enable` low and no load, `stimOut` and the slot register hold, and `changedValid` is 0.
- R11: `cfgLoad` takes priority over `enable`. A cycle that has both does not step.
- R12: Over any 63 consecutive stepping cycles with a fixed configuration, input k flips once for each nonzero slot value it owns. Slot 0 is never drawn, so it counts for nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Step one vector this cycle |
| cfgLoad | input | 1 | Load the configuration on the ports below |
| cfgSlots | input | NUM_IN*(LFSR_W+1) | Packed slot count per input |
| cfgHold | input | NUM_IN | Inputs held at their starting value |
| cfgInit | input | NUM_IN | Starting vector |
| stimOut | output | NUM_IN | Stimulus vector |
| changedValid | output | 1 | The last edge flipped one input |
| changedIdx | output | clog2(NUM_IN) | Index of the flipped input |
| cfgError | output | 1 | The last load was rejected for overflow |

## Verification
Every result is registered once. The vector, the change report and the error flag for a cycle's inputs all appear right after the next rising edge, and the slot drawn on that edge is the register value the inputs saw. The bench drives each cycle half a period before the edge and queues what that edge should produce. It compares one nanosecond after the edge, so each queued item meets the first edge that can produce it. Flip counts for R12 are gathered over exactly one register period that starts right after a load.

// File: rtl/wsic_pkg.sv
package wsic_pkg;

  // Strobes from the control side to the datapath, valid for one cycle.
  typedef struct packed {
    logic step;    // draw one slot and advance the generator
    logic loadOk;  // accepted configuration: reseed and load start vector
  } wsicStrobe_t;

endpackage

// File: rtl/wsic_lfsr.sv
module wsic_lfsr #(
  parameter int              W    = 6,
  parameter logic [W-1:0]    TAPS = 6'b110000,
  parameter logic [W-1:0]    SEED = 6'b000001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  input  logic         reseed,
  output logic [W-1:0] state
);

  logic feedback;

  assign feedback = ^(state & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEED;
    end else if (reseed) begin
      state <= SEED;
    end else if (advance) begin
      state <= {state[W-2:0], feedback};
    end
  end

endmodule

// File: rtl/wsic_bit_changer.sv
module wsic_bit_changer (
  input  logic clk,
  input  logic rst_n,
  input  logic loadInit,
  input  logic initVal,
  input  logic flip,
  output logic bitQ
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitQ <= 1'b0;
    end else if (loadInit) begin
      bitQ <= initVal;
    end else if (flip) begin
      bitQ <= ~bitQ;
    end
  end

endmodule

// File: rtl/wsic_ctrl.sv
module wsic_ctrl import wsic_pkg::*; #(
  parameter  int LFSR_W = 6,
  parameter  int NUM_IN = 8,
  localparam int CNT_W  = LFSR_W + 1,
  localparam int SUM_W  = CNT_W + $clog2(NUM_IN) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    cfgLoad,
  input  logic [NUM_IN*CNT_W-1:0] cfgSlots,
  input  logic [NUM_IN-1:0]       cfgHold,
  output wsicStrobe_t             strobe,
  output logic [SUM_W-1:0]        lowQ  [NUM_IN],
  output logic [SUM_W-1:0]        highQ [NUM_IN],
  output logic [NUM_IN-1:0]       holdQ,
  output logic                    cfgError
);

  localparam int               SLOTS      = 1 << LFSR_W;
  localparam logic [SUM_W-1:0] SLOT_TOTAL = SUM_W'(SLOTS);

  logic [SUM_W-1:0] lowNext  [NUM_IN];
  logic [SUM_W-1:0] highNext [NUM_IN];
  logic [SUM_W-1:0] total;
  logic             fits;
  logic             loadBad;

  // Running sums give each input a contiguous slot range.
  always_comb begin
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < NUM_IN; k++) begin
      lowNext[k]  = acc;
      acc         = acc + SUM_W'(cfgSlots[k*CNT_W +: CNT_W]);
      highNext[k] = acc;
    end
    total = acc;
  end

  assign fits          = (total <= SLOT_TOTAL);
  assign strobe.loadOk = cfgLoad && fits;
  assign loadBad       = cfgLoad && !fits;
  assign strobe.step   = enable && !cfgLoad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_IN; k++) begin
        lowQ[k]  <= '0;
        highQ[k] <= '0;
      end
      holdQ    <= '0;
      cfgError <= 1'b0;
    end else if (strobe.loadOk) begin
      for (int k = 0; k < NUM_IN; k++) begin
        lowQ[k]  <= lowNext[k];
        highQ[k] <= highNext[k];
      end
      holdQ    <= cfgHold;
      cfgError <= 1'b0;
    end else if (loadBad) begin
      cfgError <= 1'b1;
    end
  end

endmodule

// File: rtl/wsic_datapath.sv
module wsic_datapath import wsic_pkg::*; #(
  parameter  int                 LFSR_W = 6,
  parameter  int                 NUM_IN = 8,
  parameter  logic [LFSR_W-1:0]  TAPS   = 6'b110000,
  parameter  logic [LFSR_W-1:0]  SEED   = 6'b000001,
  localparam int                 CNT_W  = LFSR_W + 1,
  localparam int                 SUM_W  = CNT_W + $clog2(NUM_IN) + 1,
  localparam int                 IDX_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wsicStrobe_t       strobe,
  input  logic [SUM_W-1:0]  lowQ  [NUM_IN],
  input  logic [SUM_W-1:0]  highQ [NUM_IN],
  input  logic [NUM_IN-1:0] holdQ,
  input  logic [NUM_IN-1:0] cfgInit,
  output logic [NUM_IN-1:0] stimOut,
  output logic              changedValid,
  output logic [IDX_W-1:0]  changedIdx
);

  localparam int SLOTS = 1 << LFSR_W;

  logic [LFSR_W-1:0] slotState;
  logic [SLOTS-1:0]  selLine;
  logic [SLOTS-1:0]  ownMask [NUM_IN];
  logic [NUM_IN-1:0] hit;
  logic [NUM_IN-1:0] fire;
  logic              anyFire;
  logic [IDX_W-1:0]  fireIdx;

  wsic_lfsr #(
    .W    (LFSR_W),
    .TAPS (TAPS),
    .SEED (SEED)
  ) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (strobe.step),
    .reseed  (strobe.loadOk),
    .state   (slotState)
  );

  // One-of-2^n selector.
  assign selLine = SLOTS'(1) << slotState;

  for (genvar k = 0; k < NUM_IN; k++) begin : g_input
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign ownMask[k][s] = (SUM_W'(s) >= lowQ[k]) && (SUM_W'(s) < highQ[k]);
    end

    assign hit[k]  = |(selLine & ownMask[k]);
    assign fire[k] = strobe.step && hit[k] && !holdQ[k];

    wsic_bit_changer u_changer (
      .clk      (clk),
      .rst_n    (rst_n),
      .loadInit (strobe.loadOk),
      .initVal  (cfgInit[k]),
      .flip     (fire[k]),
      .bitQ     (stimOut[k])
    );
  end

  // Ranges are disjoint, so at most one bit of fire is set.
  always_comb begin
    fireIdx = '0;
    for (int k = 0; k < NUM_IN; k++) begin
      if (fire[k]) fireIdx = IDX_W'(k);
    end
  end

  assign anyFire = |fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      changedValid <= 1'b0;
      changedIdx   <= '0;
    end else begin
      changedValid <= anyFire;
      if (anyFire) changedIdx <= fireIdx;
    end
  end

endmodule

// File: rtl/wsic_pattern_gen.sv
module wsic_pattern_gen import wsic_pkg::*; #(
  parameter  int                LFSR_W = 6,
  parameter  int                NUM_IN = 8,
  parameter  logic [LFSR_W-1:0] TAPS   = 6'b110000,
  parameter  logic [LFSR_W-1:0] SEED   = 6'b000001,
  localparam int                CNT_W  = LFSR_W + 1,
  localparam int                IDX_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    cfgLoad,
  input  logic [NUM_IN*CNT_W-1:0] cfgSlots,
  input  logic [NUM_IN-1:0]       cfgHold,
  input  logic [NUM_IN-1:0]       cfgInit,
  output logic [NUM_IN-1:0]       stimOut,
  output logic                    changedValid,
  output logic [IDX_W-1:0]        changedIdx,
  output logic                    cfgError
);

  localparam int SUM_W = CNT_W + $clog2(NUM_IN) + 1;

  wsicStrobe_t       strobe;
  logic [SUM_W-1:0]  lowQ  [NUM_IN];
  logic [SUM_W-1:0]  highQ [NUM_IN];
  logic [NUM_IN-1:0] holdQ;

  wsic_ctrl #(
    .LFSR_W (LFSR_W),
    .NUM_IN (NUM_IN)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .cfgLoad  (cfgLoad),
    .cfgSlots (cfgSlots),
    .cfgHold  (cfgHold),
    .strobe   (strobe),
    .lowQ     (lowQ),
    .highQ    (highQ),
    .holdQ    (holdQ),
    .cfgError (cfgError)
  );

  wsic_datapath #(
    .LFSR_W (LFSR_W),
    .NUM_IN (NUM_IN),
    .TAPS   (TAPS),
    .SEED   (SEED)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .lowQ         (lowQ),
    .highQ        (highQ),
    .holdQ        (holdQ),
    .cfgInit      (cfgInit),
    .stimOut      (stimOut),
    .changedValid (changedValid),
    .changedIdx   (changedIdx)
  );

endmodule

// File: rtl/wsic_pattern_gen_chk.sv
module wsic_pattern_gen_chk #(
  parameter int NUM_IN = 8,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              cfgLoad,
  input logic [NUM_IN-1:0] stimOut,
  input logic [NUM_IN-1:0] holdQ,
  input logic              changedValid,
  input logic [IDX_W-1:0]  changedIdx,
  input logic              cfgError
);

  // R6
  single_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfgLoad) |-> ($countones(stimOut ^ $past(stimOut)) <= 1));

  // R4
  report_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    changedValid |-> ((stimOut ^ $past(stimOut)) == (NUM_IN'(1) << changedIdx)));

  // R5
  quiet_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!changedValid && !$past(cfgLoad)) |-> $stable(stimOut));

  // R7
  held_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfgLoad) |-> ((holdQ & (stimOut ^ $past(stimOut))) == '0));

  // R9
  reject_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfgError) |-> ($stable(stimOut) && !changedValid));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !cfgLoad) |=> (!changedValid && $stable(stimOut)));

  // R11
  load_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfgLoad |=> !changedValid);

endmodule

bind wsic_pattern_gen wsic_pattern_gen_chk #(
  .NUM_IN (NUM_IN),
  .IDX_W  (IDX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .cfgLoad      (cfgLoad),
  .stimOut      (stimOut),
  .holdQ        (holdQ),
  .changedValid (changedValid),
  .changedIdx   (changedIdx),
  .cfgError     (cfgError)
);

// File: tb/wsic_pattern_gen_tb.sv
`timescale 1ns/1ps
module wsic_pattern_gen_tb;

  localparam int LW    = 6;
  localparam int NI    = 8;
  localparam int CW    = LW + 1;
  localparam int IW    = 3;
  localparam int SLOTS = 1 << LW;
  localparam logic [LW-1:0] TAPS = 6'b110000;
  localparam logic [LW-1:0] SEED = 6'b000001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic cfgLoad = 1'b0;
  logic [NI*CW-1:0] cfgSlots = '0;
  logic [NI-1:0] cfgHold = '0;
  logic [NI-1:0] cfgInit = '0;
  logic [NI-1:0] stimOut;
  logic changedValid;
  logic [IW-1:0] changedIdx;
  logic cfgError;

  always #10 clk = ~clk;

  wsic_pattern_gen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfgLoad(cfgLoad),
    .cfgSlots(cfgSlots), .cfgHold(cfgHold), .cfgInit(cfgInit),
    .stimOut(stimOut), .changedValid(changedValid),
    .changedIdx(changedIdx), .cfgError(cfgError)
  );

  typedef struct {
    logic [NI-1:0] stim;
    logic          valid;
    logic [IW-1:0] idx;
    logic          err;
    logic          isLoad;
    string         tag;
  } exp_t;

  exp_t q[$];

  logic [LW-1:0] mLfsr;
  logic [NI-1:0] mStim;
  logic [NI-1:0] mHold;
  logic          mErr;
  int            mLow [NI];
  int            mHigh[NI];
  int            togCount[NI];
  int            checks = 0;
  int            fails = 0;
  bit            done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [NI*CW-1:0] packSlots(input int v [NI]);
    logic [NI*CW-1:0] r;
    r = '0;
    for (int k = 0; k < NI; k++) r[k*CW +: CW] = CW'(v[k]);
    return r;
  endfunction

  // Driver: applies one cycle of inputs and queues the expected result.
  task automatic drive(input logic en, input logic ld, input logic [NI*CW-1:0] sl,
                       input logic [NI-1:0] hd, input logic [NI-1:0] ini);
    exp_t e;
    int sum;
    int acc;
    int hitK;
    @(negedge clk);
    enable = en; cfgLoad = ld; cfgSlots = sl; cfgHold = hd; cfgInit = ini;
    e.isLoad = ld; e.valid = 1'b0; e.idx = '0;
    if (ld) begin
      sum = 0;
      for (int k = 0; k < NI; k++) sum += int'(sl[k*CW +: CW]);
      if (sum > SLOTS) begin
        mErr = 1'b1;
        e.tag = en ? "R9 R11" : "R9";
      end else begin
        acc = 0;
        for (int k = 0; k < NI; k++) begin
          mLow[k] = acc;
          acc += int'(sl[k*CW +: CW]);
          mHigh[k] = acc;
        end
        mHold = hd; mStim = ini; mLfsr = SEED; mErr = 1'b0;
        e.tag = en ? "R8 R11" : "R8";
      end
    end else if (en) begin
      hitK = -1;
      for (int k = 0; k < NI; k++)
        if (int'(mLfsr) >= mLow[k] && int'(mLfsr) < mHigh[k]) hitK = k;
      if (hitK >= 0 && !mHold[hitK]) begin
        mStim[hitK] = ~mStim[hitK];
        e.valid = 1'b1;
        e.idx = IW'(hitK);
        e.tag = "R2 R3 R4";
      end else if (hitK >= 0) begin
        e.tag = "R7";
      end else begin
        e.tag = "R5";
      end
      mLfsr = {mLfsr[LW-2:0], ^(mLfsr & TAPS)};
    end else begin
      e.tag = "R10";
    end
    e.stim = mStim; e.err = mErr;
    q.push_back(e);
  endtask

  task automatic drain();
    @(negedge clk);
    enable = 1'b0; cfgLoad = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b0, cfgSlots, cfgHold, cfgInit);
  endtask

  task automatic clearCounts();
    for (int k = 0; k < NI; k++) togCount[k] = 0;
  endtask

  // R12: one full period flips each input once per nonzero owned slot.
  task automatic checkCounts();
    int cnt;
    for (int k = 0; k < NI; k++) begin
      cnt = 0;
      for (int s = 1; s < SLOTS; s++)
        if (s >= mLow[k] && s < mHigh[k] && !mHold[k]) cnt++;
      chk(togCount[k] == cnt, "R12", togCount[k], cnt);
    end
  endtask

  // Monitor: compares one cycle after each driven edge.
  initial begin
    exp_t e;
    logic [NI-1:0] prev;
    prev = '0;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && q.size() > 0) begin
        e = q.pop_front();
        chk(stimOut == e.stim && changedValid == e.valid && cfgError == e.err &&
            (!e.valid || changedIdx == e.idx), e.tag,
            {20'd0, stimOut, changedValid, changedIdx, cfgError},
            {20'd0, e.stim, e.valid, e.idx, e.err});
        if (!e.isLoad) begin
          chk($countones(prev ^ stimOut) <= 1, "R6", prev ^ stimOut, 0);
          for (int k = 0; k < NI; k++) if (prev[k] != stimOut[k]) togCount[k]++;
        end
      end
      prev = stimOut;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    mLfsr = SEED; mStim = '0; mHold = '0; mErr = 1'b0;
    for (int k = 0; k < NI; k++) begin mLow[k] = 0; mHigh[k] = 0; end
    clearCounts();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    // R1 reset state
    chk(stimOut == '0 && !changedValid && !cfgError, "R1",
        {stimOut, changedValid, cfgError}, 0);
    // R1 / R5: empty configuration gives no change
    run(5);
    drain();

    // Weighted configuration, full period
    drive(1'b0, 1'b1, packSlots('{20, 10, 5, 5, 8, 4, 2, 3}), 8'h00, 8'hA5);
    drain(); clearCounts();
    run(63);
    drain(); checkCounts();

    // R10 idle cycles interleaved with steps
    for (int i = 0; i < 4; i++) begin
      drive(1'b0, 1'b0, cfgSlots, cfgHold, cfgInit);
      drive(1'b1, 1'b0, cfgSlots, cfgHold, cfgInit);
    end

    // R9 overflow rejected, old configuration keeps running
    drive(1'b0, 1'b1, packSlots('{20, 10, 10, 10, 10, 5, 3, 2}), 8'h00, 8'hFF);
    run(10);
    drive(1'b1, 1'b1, packSlots('{30, 30, 5, 0, 0, 0, 0, 0}), 8'h00, 8'h3C);
    run(4);
    drain();

    // R7 held inputs
    drive(1'b0, 1'b1, packSlots('{30, 2, 20, 2, 2, 2, 2, 2}), 8'h05, 8'h0F);
    drain(); clearCounts();
    run(63);
    drain(); checkCounts();

    // R8 / R11 boundary: sum exactly 64, load together with enable
    drive(1'b1, 1'b1, packSlots('{8, 8, 8, 8, 8, 8, 8, 8}), 8'h00, 8'h00);
    drain(); clearCounts();
    run(63);
    drain(); checkCounts();

    // R3 boundary: one input owns the whole slot space
    drive(1'b0, 1'b1, packSlots('{0, 0, 0, 0, 0, 0, 0, 64}), 8'h00, 8'hFF);
    run(10);
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule